// File: doc/BRIEF.md
# Branch Target Buffer with Two-Outcome History

This block is a direct-mapped branch target buffer that a fetch stage consults with every fetch address. Each slot holds a valid flag, an address tag, the last known target of the branch, and the outcomes of the two most recent executions of that branch. A lookup that matches a valid slot returns a hit, a taken or not-taken guess, the stored target and the raw two-outcome history. A lookup that matches nothing returns a miss with every other output at zero.

When a branch resolves, the back end presents one update per cycle with the branch address, whether it was taken, and where it went. If the addressed slot already belongs to that branch, the new outcome is shifted into the history and the target is refreshed. Otherwise the slot is taken over: tag and target are written and the history is seeded with the actual outcome in both positions. The lookup path is purely combinational. An update becomes visible on the cycle after it is presented, and it is not forwarded to a lookup of the same slot in the same cycle.

Top module: `btb_top`

## Requirements
- R1: After a synchronous active-high reset every slot is invalid, so every lookup misses until an update writes the slot.
- R2: On a lookup miss, look_hit, look_taken, look_target and look_hist are all zero.
- R3: An update whose address misses writes the tag and target into the indexed slot and sets look_hist to 2'b11 for a taken outcome or 2'b00 for a not-taken outcome.
- R4: An update that hits shifts its history: the new look_hist is {old look_hist[0], outcome}, where bit 0 is the most recent outcome and bit 1 the one before it (1 = taken).
- R5: On a hit, look_taken equals look_hist[0]: histories 2'b01 and 2'b11 predict taken, 2'b00 and 2'b10 predict not taken.
- R6: Every update, hit or miss, stores its target, so the next lookup of that branch returns the newest target.
- R7: The slot is chosen by address bits [6:2] and the tag is bits [31:7]; a lookup with a matching index but a different tag misses, and an update with a different tag replaces the slot.
- R8: State changes only through updates, and an update is visible from the following cycle; a lookup in the same cycle as an update to its slot returns the slot's earlier contents.
- R9: Address bits [1:0] take no part in indexing or tag matching.
- R10: An update changes only the slot it indexes; other slots keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_addr | input | 32 | Fetch address to look up |
| look_hit | output | 1 | Valid slot with matching tag |
| look_taken | output | 1 | Predicted direction, 1 = taken |
| look_target | output | 32 | Stored target of the matching branch |
| look_hist | output | 2 | Stored outcomes, bit 0 most recent, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | 32 | Actual target address |

## Verification
Every cycle the assertions check that a miss drives quiet outputs, that a hit's direction follows the newest history bit, that outputs hold steady when neither the address nor the table changed, and that an update looked up on the next cycle shows either the seeded history or the shifted history with the new target. Tag replacement within one slot, independence of neighbouring slots, the ignored offset bits and the stale result of a same-cycle lookup rely on address pairs chosen by the bench scenarios. The clearing effect of a reset applied to a full table is shown only by the bench's final directed test.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int ADDR_W = 32;
    localparam int OFFS_W = 2;
    localparam int DEPTH  = 32;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
    localparam int HIST_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [HIST_W-1:0] hist_t;

    typedef struct packed {
        idx_t idx;
        tag_t tag;
    } key_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        addr_t target;
        hist_t hist;
    } entry_t;

    typedef struct packed {
        logic  valid;
        logic  taken;
        addr_t target;
    } upd_t;

    typedef struct packed {
        logic  hit;
        logic  taken;
        addr_t target;
        hist_t hist;
    } pred_t;

    // newest outcome enters bit 0, the older bit moves up, the oldest drops
    function automatic hist_t hist_shift(hist_t h, logic outcome);
        return {h[0], outcome};
    endfunction

    function automatic hist_t hist_seed(logic outcome);
        return {HIST_W{outcome}};
    endfunction

    function automatic logic hist_guess(hist_t h);
        return h[0];
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split
    import btb_pkg::*;
(
    input  addr_t addr,
    output key_t  key
);

    logic unused_offs;

    assign key.idx     = addr[OFFS_W +: IDX_W];
    assign key.tag     = addr[ADDR_W-1 -: TAG_W];
    assign unused_offs = ^addr[OFFS_W-1:0];

endmodule

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  upd_t   upd,
    input  key_t   upd_key,
    input  idx_t   rd_idx,
    output entry_t rd_entry
);

    entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        entry_t slot_q;
        logic   wr_sel;
        logic   owner;

        assign wr_sel = upd.valid && (upd_key.idx == idx_t'(g));
        assign owner  = slot_q.valid && (slot_q.tag == upd_key.tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_sel) begin
                slot_q.valid  <= 1'b1;
                slot_q.tag    <= upd_key.tag;
                slot_q.target <= upd.target;
                slot_q.hist   <= owner ? hist_shift(slot_q.hist, upd.taken)
                                       : hist_seed(upd.taken);
            end
        end

        assign slots[g] = slot_q;
    end

    assign rd_entry = slots[rd_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  key_t   key,
    input  entry_t ent,
    output pred_t  pred
);

    logic match;

    assign match = ent.valid && (ent.tag == key.tag);

    always_comb begin
        pred = '0;
        if (match) begin
            pred.hit    = 1'b1;
            pred.taken  = hist_guess(ent.hist);
            pred.target = ent.target;
            pred.hist   = ent.hist;
        end
    end

endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] look_addr,
    output logic        look_hit,
    output logic        look_taken,
    output logic [31:0] look_target,
    output logic [1:0]  look_hist,
    input  logic        upd_valid,
    input  logic [31:0] upd_addr,
    input  logic        upd_taken,
    input  logic [31:0] upd_target
);

    key_t   rd_key;
    key_t   wr_key;
    upd_t   upd;
    entry_t rd_entry;
    pred_t  pred;

    assign upd.valid  = upd_valid;
    assign upd.taken  = upd_taken;
    assign upd.target = upd_target;

    btb_addr_split i_split_rd (
        .addr (look_addr),
        .key  (rd_key)
    );

    btb_addr_split i_split_wr (
        .addr (upd_addr),
        .key  (wr_key)
    );

    btb_table i_table (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .upd_key  (wr_key),
        .rd_idx   (rd_key.idx),
        .rd_entry (rd_entry)
    );

    btb_lookup i_lookup (
        .key  (rd_key),
        .ent  (rd_entry),
        .pred (pred)
    );

    assign look_hit    = pred.hit;
    assign look_taken  = pred.taken;
    assign look_target = pred.target;
    assign look_hist   = pred.hist;

endmodule

// File: rtl/btb_chk.sv
module btb_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] look_addr,
    input logic        look_hit,
    input logic        look_taken,
    input logic [31:0] look_target,
    input logic [1:0]  look_hist,
    input logic        upd_valid,
    input logic [31:0] upd_addr,
    input logic        upd_taken,
    input logic [31:0] upd_target
);

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !look_hit);

    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !look_hit |-> (!look_taken && look_target == 32'd0 && look_hist == 2'b00));

    // R3 and R6: a missing update reappears seeded, with its target
    p_seed_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid) && !$past(look_hit)
         && $past(look_addr) == $past(upd_addr) && look_addr == $past(upd_addr))
        |-> (look_hit && look_hist == {2{$past(upd_taken)}}
             && look_target == $past(upd_target)));

    // R4 and R6: a hitting update shifts the history and refreshes the target
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid) && $past(look_hit)
         && $past(look_addr) == $past(upd_addr) && look_addr == $past(upd_addr))
        |-> (look_hit && look_hist == {$past(look_hist[0]), $past(upd_taken)}
             && look_target == $past(upd_target)));

    p_guess_recent_r5: assert property (@(posedge clk) disable iff (rst)
        look_hit |-> (look_taken == look_hist[0]));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_valid) && $stable(look_addr))
        |-> ($stable(look_hit) && $stable(look_target) && $stable(look_hist)));

endmodule

bind btb_top btb_chk i_chk (.*);

// File: tb/test_btb_top.sv
module test_btb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] look_addr = '0;
    logic        look_hit;
    logic        look_taken;
    logic [31:0] look_target;
    logic [1:0]  look_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    btb_top i_btb_top (.*);

    typedef struct packed {
        logic        uv;
        logic [31:0] ua;
        logic        ut;
        logic [31:0] utg;
        logic [31:0] la;
        logic        eh;
        logic        et;
        logic [1:0]  ehist;
        logic [31:0] etg;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] A  = 32'h0000_1004; // slot 1
    localparam logic [31:0] A3 = 32'h0000_1007; // slot 1, offset differs
    localparam logic [31:0] B  = 32'h0000_2004; // slot 1, other tag
    localparam logic [31:0] C  = 32'h0000_1008; // slot 2
    localparam int NV = 13;

    // expected lookup values are those before the row's update lands
    localparam vec_t VECS [NV] = '{
        '{1'b1, A, 1'b1, 32'h100, A,  1'b0, 1'b0, 2'b00, 32'h0,   4'd2},  // R2 empty
        '{1'b1, A, 1'b0, 32'h100, A,  1'b1, 1'b1, 2'b11, 32'h100, 4'd3},  // R3 seeded T
        '{1'b0, A, 1'b0, 32'h0,   A,  1'b1, 1'b0, 2'b10, 32'h100, 4'd4},  // R4 shift
        '{1'b1, A, 1'b1, 32'h180, A,  1'b1, 1'b0, 2'b10, 32'h100, 4'd5},  // R5 10 not taken
        '{1'b1, C, 1'b0, 32'h200, A3, 1'b1, 1'b1, 2'b01, 32'h180, 4'd9},  // R9 R6 R5
        '{1'b0, C, 1'b0, 32'h0,   C,  1'b1, 1'b0, 2'b00, 32'h200, 4'd3},  // R3 seeded N
        '{1'b1, B, 1'b1, 32'h300, B,  1'b0, 1'b0, 2'b00, 32'h0,   4'd7},  // R7 tag miss
        '{1'b0, B, 1'b0, 32'h0,   A,  1'b0, 1'b0, 2'b00, 32'h0,   4'd7},  // R7 replaced
        '{1'b0, B, 1'b0, 32'h0,   B,  1'b1, 1'b1, 2'b11, 32'h300, 4'd7},  // R7 new owner
        '{1'b0, B, 1'b0, 32'h0,   C,  1'b1, 1'b0, 2'b00, 32'h200, 4'd10}, // R10 untouched
        '{1'b1, C, 1'b1, 32'h204, C,  1'b1, 1'b0, 2'b00, 32'h200, 4'd8},  // R8 stale read
        '{1'b1, C, 1'b1, 32'h204, C,  1'b1, 1'b1, 2'b01, 32'h204, 4'd6},  // R6 R4
        '{1'b0, C, 1'b0, 32'h0,   C,  1'b1, 1'b1, 2'b11, 32'h204, 4'd4}   // R4 TT
    };

    task automatic check(input string tag, input logic h, input logic t,
                         input logic [1:0] hs, input logic [31:0] tg);
        checks++;
        if (look_hit !== h || look_taken !== t || look_hist !== hs || look_target !== tg) begin
            errors++;
            $display("FAIL %s: got hit=%b taken=%b hist=%b target=%h, expected hit=%b taken=%b hist=%b target=%h",
                     tag, look_hit, look_taken, look_hist, look_target, h, t, hs, tg);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        look_addr = A;
        #1 check("R1 after reset", 1'b0, 1'b0, 2'b00, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            upd_valid  = VECS[i].uv;
            upd_addr   = VECS[i].ua;
            upd_taken  = VECS[i].ut;
            upd_target = VECS[i].utg;
            look_addr  = VECS[i].la;
            #1 check($sformatf("R%0d row %0d", VECS[i].req, i),
                     VECS[i].eh, VECS[i].et, VECS[i].ehist, VECS[i].etg);
        end

        @(negedge clk);
        upd_valid = 1'b0;
        look_addr = C;
        #1 check("R4 hold", 1'b1, 1'b1, 2'b11, 32'h204);

        // R1: reset clears a populated table
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1 slot 2 cleared", 1'b0, 1'b0, 2'b00, 32'h0);
        look_addr = B;
        #1 check("R1 slot 1 cleared", 1'b0, 1'b0, 2'b00, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule